// File: doc/BRIEF.md
# DMA Interrupt Status and Summary Register

This block is the interrupt status register of a packet DMA engine with a transmit path and a receive path. Each hardware event pulse sets its own sticky status bit. Software reads the status word and clears any bit by writing a one to that bit's position. The sources fall into two fixed groups, normal and abnormal. Each group has its own sticky summary bit. A source reaches its group's summary only while its bit is set in a separate enable register.

The receive path also feeds in the length of every completed frame. A frame that is too long raises the receive watchdog status on its own. The early-receive flag is dropped automatically when a receive-done event arrives. A latched bus error forces a bus-disable output for the DMA engine. The 3-bit receive engine state is passed straight through into the status word as a read-only field. One interrupt line is driven from the two summary bits, and each summary bit has its own enable.

The register port is a simple 32-bit synchronous port with byte addresses. The status word is at 0x00 and the enable word at 0x04. Read data appears one cycle after the read strobe.

Top module: `dis_irq_status`

## Requirements
- R1: A one-cycle pulse on `ev_pulse[i]` sets status bit i at the next clock edge, for i in {0..8, 10, 13, 14}. Bits 9, 11 and 12 of `ev_pulse` have no effect.
- R2: A write to the status word (address 0x00) clears each source bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged. If a set pulse and a clear reach the same bit in the same cycle, the bit ends up set.
- R3: When `rx_frame_end` is high, `rx_frame_len` greater than MAX_FRAME (default 2048) sets status bit 9 two edges later. A length of exactly MAX_FRAME does not set it.
- R4: A receive-done pulse (`ev_pulse[6]`) clears the early-receive bit 14. It wins over an early-receive pulse in the same cycle.
- R5: Normal summary bit 16 sets one edge after any of status bits 0, 2, 6, 14 is set together with the enable-word bit at the same position.
- R6: Abnormal summary bit 15 sets the same way over status bits 1, 3, 4, 5, 7, 8, 9, 10, 13. A source in one group never sets the other group's summary bit.
- R7: A source whose enable bit is 0 still latches its status bit but does not set a summary bit.
- R8: Both summary bits are sticky. A write of 1 clears them. While an enabled source in the group is still set, the summary bit sets again at the next edge.
- R9: `irq_out` is a registered OR of (bit 16 AND enable bit 16) and (bit 15 AND enable bit 15). It falls one edge after the summary bits clear.
- R10: `dma_bus_off` is high exactly while status bit 13 is set.
- R11: Status bits 19:17 show `rx_dma_state` at the read edge. Bits 12:11 and 31:20 always read zero, and writes to them are ignored.
- R12: Reset clears all status, summary and enable bits, `irq_out` and the read data. The enable word reads back what was written to bits 0..10, 13..16, with all other bits zero. Read data is registered, so it is valid one cycle after `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address (0x00 status, 0x04 enable) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_pulse | input | 15 | One-cycle event pulses, indexed by status bit |
| rx_frame_end | input | 1 | Received frame complete; length valid |
| rx_frame_len | input | 16 | Byte length of the completed frame |
| rx_dma_state | input | 3 | Receive engine state code |
| irq_out | output | 1 | Interrupt request |
| dma_bus_off | output | 1 | Disables all DMA bus accesses |

## Verification
The summary logic is driven with four kinds of pattern. A masked source shows that latching and summarising are separate. A normal-only and an abnormal-only source show which group each bit belongs to. Clearing a summary bit while its source is still set shows that the bit is sticky and sets again. The interrupt fall is checked cycle by cycle, which shows whether it is registered or combinational. Frames of exactly the limit and one byte over it show where the watchdog threshold lies. Set and clear in the same cycle, and receive-done together with early receive, show which side wins each conflict.

// File: rtl/dis_pkg.sv
package dis_pkg;

    localparam int DW      = 32;
    localparam int AW      = 8;
    localparam int NSRC    = 15;

    // status bit positions (decoded by software)
    localparam int B_TX_DONE  = 0;
    localparam int B_TX_STOP  = 1;
    localparam int B_TX_NOBUF = 2;
    localparam int B_JABBER   = 3;
    localparam int B_RX_OVF   = 4;
    localparam int B_TX_UNF   = 5;
    localparam int B_RX_DONE  = 6;
    localparam int B_RX_NOBUF = 7;
    localparam int B_RX_STOP  = 8;
    localparam int B_RX_WDOG  = 9;
    localparam int B_EARLY_TX = 10;
    localparam int B_BUS_ERR  = 13;
    localparam int B_EARLY_RX = 14;
    localparam int B_ABN_SUM  = 15;
    localparam int B_NRM_SUM  = 16;
    localparam int RXS_LSB    = 17;
    localparam int RXS_W      = 3;

    localparam logic [AW-1:0] ADDR_STATUS = 8'h00;
    localparam logic [AW-1:0] ADDR_ENABLE = 8'h04;

    localparam logic [NSRC-1:0] NORM_GRP =
        NSRC'((1 << B_TX_DONE) | (1 << B_TX_NOBUF) | (1 << B_RX_DONE) | (1 << B_EARLY_RX));
    localparam logic [NSRC-1:0] ABN_GRP =
        NSRC'((1 << B_TX_STOP) | (1 << B_JABBER) | (1 << B_RX_OVF) | (1 << B_TX_UNF) |
              (1 << B_RX_NOBUF) | (1 << B_RX_STOP) | (1 << B_RX_WDOG) |
              (1 << B_EARLY_TX) | (1 << B_BUS_ERR));
    localparam logic [NSRC-1:0] SRC_MASK = NORM_GRP | ABN_GRP;
    // event pins that may set a bit directly (watchdog comes from the length check)
    localparam logic [NSRC-1:0] EV_MASK  = SRC_MASK & ~NSRC'(1 << B_RX_WDOG);

    localparam logic [DW-1:0] EN_WMASK =
        DW'(SRC_MASK) | DW'(1 << B_ABN_SUM) | DW'(1 << B_NRM_SUM);

    typedef enum logic [RXS_W-1:0] {
        RXS_STOP  = 3'b000,
        RXS_FETCH = 3'b001,
        RXS_WAIT  = 3'b011,
        RXS_SUSP  = 3'b100,
        RXS_CLOSE = 3'b101,
        RXS_XFER  = 3'b111
    } rx_state_e;

    typedef struct packed {
        logic nrm;
        logic abn;
    } sum_t;

    function automatic logic [DW-1:0] pack_status(input logic [RXS_W-1:0] rxs,
                                                  input sum_t sum,
                                                  input logic [NSRC-1:0] src);
        logic [DW-1:0] w;
        w = '0;
        w[NSRC-1:0]                  = src & SRC_MASK;
        w[B_ABN_SUM]                 = sum.abn;
        w[B_NRM_SUM]                 = sum.nrm;
        w[RXS_LSB +: RXS_W]          = rxs;
        return w;
    endfunction

endpackage

// File: rtl/dis_frame_wdog.sv
module dis_frame_wdog #(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end,
    input  logic [LEN_W-1:0] frame_len,
    output logic             wd_pulse
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_FRAME);

    always_ff @(posedge clk) begin
        if (rst) wd_pulse <= 1'b0;
        else     wd_pulse <= frame_end && (frame_len > LIMIT);
    end

    a_r3_long_frame_flags: assert property (@(posedge clk) disable iff (rst)
        (frame_end && frame_len > LIMIT) |=> wd_pulse);
    a_r3_short_frame_quiet: assert property (@(posedge clk) disable iff (rst)
        !(frame_end && frame_len > LIMIT) |=> !wd_pulse);
endmodule

// File: rtl/dis_src_latch.sv
module dis_src_latch #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           q[i] <= 1'b0;
            else if (set_v[i]) q[i] <= 1'b1;   // set wins over clear
            else if (clr_v[i]) q[i] <= 1'b0;
        end
    end

    a_r1_set_lands: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((q & $past(set_v)) == $past(set_v)));
    a_r2_clear_lands: assert property (@(posedge clk) disable iff (rst)
        ((clr_v & ~set_v) != '0) |=> ((q & $past(clr_v & ~set_v)) == '0));
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        ((set_v | clr_v) == '0) |=> (q == $past(q)));
endmodule

// File: rtl/dis_summary.sv
module dis_summary
    import dis_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  logic [DW-1:0]   en,
    input  logic            clr_nrm,
    input  logic            clr_abn,
    output sum_t            sum,
    output logic            irq
);
    logic nrm_hit, abn_hit;

    always_comb begin
        nrm_hit = |(src & en[NSRC-1:0] & NORM_GRP);
        abn_hit = |(src & en[NSRC-1:0] & ABN_GRP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
            irq <= 1'b0;
        end else begin
            sum.nrm <= (sum.nrm & ~clr_nrm) | nrm_hit;
            sum.abn <= (sum.abn & ~clr_abn) | abn_hit;
            irq     <= (sum.nrm & en[B_NRM_SUM]) | (sum.abn & en[B_ABN_SUM]);
        end
    end

    a_r8_nrm_sticky: assert property (@(posedge clk) disable iff (rst)
        (sum.nrm && !clr_nrm) |=> sum.nrm);
    a_r8_abn_sticky: assert property (@(posedge clk) disable iff (rst)
        (sum.abn && !clr_abn) |=> sum.abn);
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (((src & en[NSRC-1:0]) == '0) && !sum.nrm && !sum.abn) |=> (!sum.nrm && !sum.abn));
    a_r6_abn_only: assert property (@(posedge clk) disable iff (rst)
        (((src & NORM_GRP) == '0) && !sum.nrm) |=> !sum.nrm);
    a_r9_irq_drop: assert property (@(posedge clk) disable iff (rst)
        (!sum.nrm && !sum.abn) |=> !irq);
endmodule

// File: rtl/dis_regport.sv
module dis_regport
    import dis_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] status_word,
    output logic [DW-1:0] en_q,
    output logic [DW-1:0] sts_clr,
    output logic [DW-1:0] rdata
);
    logic wr_sts, wr_en;

    always_comb begin
        wr_sts  = wr && (addr == ADDR_STATUS);
        wr_en   = wr && (addr == ADDR_ENABLE);
        sts_clr = wr_sts ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= wdata & EN_WMASK;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else if (rd) begin
            case (addr)
                ADDR_STATUS: rdata <= status_word;
                ADDR_ENABLE: rdata <= en_q;
                default:     rdata <= '0;
            endcase
        end
    end

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rdata[12:11] == 2'b00) && (rdata[DW-1:RXS_LSB+RXS_W] == '0));
    a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/dis_irq_status.sv
module dis_irq_status
    import dis_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MAX_FRAME = 2048
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NSRC-1:0]   ev_pulse,
    input  logic              rx_frame_end,
    input  logic [LEN_W-1:0]  rx_frame_len,
    input  logic [RXS_W-1:0]  rx_dma_state,
    output logic              irq_out,
    output logic              dma_bus_off
);
    logic [NSRC-1:0] set_v, clr_v, src_q;
    logic [DW-1:0]   en_q, sts_clr, status_word;
    logic            wd_pulse;
    sum_t            sum;
    rx_state_e       rxs;

    dis_frame_wdog #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME)) u_wdog (
        .clk(clk), .rst(rst),
        .frame_end(rx_frame_end), .frame_len(rx_frame_len),
        .wd_pulse(wd_pulse)
    );

    always_comb begin
        set_v             = ev_pulse & EV_MASK;
        set_v[B_RX_WDOG]  = wd_pulse;
        // receive-done drops early-receive and beats a same-cycle early pulse
        set_v[B_EARLY_RX] = ev_pulse[B_EARLY_RX] & ~ev_pulse[B_RX_DONE];
        clr_v             = sts_clr[NSRC-1:0] & SRC_MASK;
        clr_v[B_EARLY_RX] = clr_v[B_EARLY_RX] | ev_pulse[B_RX_DONE];
    end

    dis_src_latch #(.N(NSRC)) u_latch (
        .clk(clk), .rst(rst), .set_v(set_v), .clr_v(clr_v), .q(src_q)
    );

    dis_summary u_sum (
        .clk(clk), .rst(rst), .src(src_q), .en(en_q),
        .clr_nrm(sts_clr[B_NRM_SUM]), .clr_abn(sts_clr[B_ABN_SUM]),
        .sum(sum), .irq(irq_out)
    );

    always_comb begin
        rxs         = rx_state_e'(rx_dma_state);
        status_word = pack_status(rxs, sum, src_q);
        dma_bus_off = src_q[B_BUS_ERR];
    end

    dis_regport u_port (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .status_word(status_word),
        .en_q(en_q), .sts_clr(sts_clr), .rdata(reg_rdata)
    );

    a_r4_early_rx_dropped: assert property (@(posedge clk) disable iff (rst)
        ev_pulse[B_RX_DONE] |=> !src_q[B_EARLY_RX]);
    a_r10_bus_off_held: assert property (@(posedge clk) disable iff (rst)
        (ev_pulse[B_BUS_ERR]) |=> dma_bus_off);
    a_r1_unused_pins: assert property (@(posedge clk) disable iff (rst)
        (!src_q[11] && !src_q[12]));
endmodule

// File: tb/dis_irq_status_test.sv
module dis_irq_status_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [14:0] ev_pulse = '0;
    logic        rx_frame_end = 1'b0;
    logic [15:0] rx_frame_len = '0;
    logic [2:0]  rx_dma_state = '0;
    logic        irq_out, dma_bus_off;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] A_STS = 8'h00;
    localparam logic [7:0] A_EN  = 8'h04;

    always #5 clk = ~clk;

    dis_irq_status uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse),
        .rx_frame_end(rx_frame_end), .rx_frame_len(rx_frame_len),
        .rx_dma_state(rx_dma_state), .irq_out(irq_out), .dma_bus_off(dma_bus_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [14:0] e);
        @(negedge clk); ev_pulse = e;
        @(negedge clk); ev_pulse = '0;
    endtask

    task automatic frame(input logic [15:0] len);
        @(negedge clk); rx_frame_end = 1'b1; rx_frame_len = len;
        @(negedge clk); rx_frame_end = 1'b0;
    endtask

    task automatic clear_all();
        wr(A_EN, 32'h0);
        wr(A_STS, 32'hFFFF_FFFF);
        tick(2);
        wr(A_STS, 32'hFFFF_FFFF);
        tick(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R12 irq after reset", {31'b0, irq_out}, 32'h0);
        check("R12 bus_off after reset", {31'b0, dma_bus_off}, 32'h0);
        check("R12 rdata after reset", reg_rdata, 32'h0);
        rd(A_STS, d); check("R12 status after reset", d, 32'h0);
        rd(A_EN, d);  check("R12 enable after reset", d, 32'h0);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d);  check("R12 enable writable mask", d, 32'h0001_E7FF);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] d;
        clear_all();
        pulse(15'h0009);
        rd(A_STS, d); check("R1 bits 0,3 set", d, 32'h0000_0009);
        pulse(15'h1A00);
        rd(A_STS, d); check("R1 pins 9,11,12 ignored", d, 32'h0000_0009);
        wr(A_STS, 32'h0);
        rd(A_STS, d); check("R2 write zero no effect", d, 32'h0000_0009);
        wr(A_STS, 32'h1);
        rd(A_STS, d); check("R2 write one clears bit0", d, 32'h0000_0008);
        @(negedge clk); ev_pulse = 15'h0004; reg_wr = 1'b1; reg_addr = A_STS; reg_wdata = 32'h4;
        @(negedge clk); ev_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
        rd(A_STS, d); check("R2 set wins over clear", d, 32'h0000_000C);
    endtask

    task automatic t_wdog();
        logic [31:0] d;
        clear_all();
        frame(16'd2048); tick(2);
        rd(A_STS, d); check("R3 exactly limit", d, 32'h0);
        frame(16'd2049); tick(2);
        rd(A_STS, d); check("R3 over limit sets bit9", d, 32'h0000_0200);
    endtask

    task automatic t_early_rx();
        logic [31:0] d;
        clear_all();
        pulse(15'h4000);
        rd(A_STS, d); check("R4 early rx set", d, 32'h0000_4000);
        pulse(15'h0040);
        rd(A_STS, d); check("R4 rx done clears early rx", d, 32'h0000_0040);
        pulse(15'h4040);
        rd(A_STS, d); check("R4 rx done wins same cycle", d, 32'h0000_0040);
    endtask

    task automatic t_summary();
        logic [31:0] d;
        clear_all();
        pulse(15'h0001); tick(3);
        rd(A_STS, d); check("R7 masked source latches only", d, 32'h0000_0001);
        wr(A_EN, 32'h1); tick(3);
        rd(A_STS, d); check("R5 normal summary set", d, 32'h0001_0001);
        check("R9 irq off while summary enable clear", {31'b0, irq_out}, 32'h0);
        wr(A_EN, 32'h0001_0001); tick(3);
        check("R9 irq on", {31'b0, irq_out}, 32'h1);
        wr(A_STS, 32'h0001_0000); tick(3);
        rd(A_STS, d); check("R8 summary re-sets with source held", d, 32'h0001_0001);
        wr(A_STS, 32'h1); tick(2);
        wr(A_STS, 32'h0001_0000);
        check("R9 irq still high one cycle", {31'b0, irq_out}, 32'h1);
        tick(1);
        check("R9 irq falls next cycle", {31'b0, irq_out}, 32'h0);
        // group separation: all sources enabled
        clear_all();
        wr(A_EN, 32'h0001_E7FF);
        pulse(15'h0008); tick(3);
        rd(A_STS, d); check("R6 abnormal source only abnormal summary", d, 32'h0000_8008);
        check("R6 irq via abnormal", {31'b0, irq_out}, 32'h1);
        clear_all();
        wr(A_EN, 32'h0000_A000);
        pulse(15'h2000);
        check("R10 bus off set", {31'b0, dma_bus_off}, 32'h1);
        tick(3);
        rd(A_STS, d); check("R6 bus error abnormal summary", d, 32'h0000_A000);
        check("R10 bus off held", {31'b0, dma_bus_off}, 32'h1);
        wr(A_STS, 32'h2000);
        check("R10 bus off released", {31'b0, dma_bus_off}, 32'h0);
    endtask

    task automatic t_rx_state();
        logic [31:0] d;
        clear_all();
        rx_dma_state = 3'b101;
        rd(A_STS, d); check("R11 rx state field", d, 32'h000A_0000);
        rx_dma_state = 3'b111;
        wr(A_STS, 32'hFFF0_1800);
        rd(A_STS, d); check("R11 reserved bits stay zero", d, 32'h000E_0000);
        rx_dma_state = 3'b000;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        t_reset();
        t_set_clear();
        t_wdog();
        t_early_rx();
        t_summary();
        t_rx_state();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule